// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one DMA channel that software sets up through a small register window. It copies data from a source address to a destination address, one unit at a time. Each unit is a read followed by a write on a single-beat memory request port. The unit is a byte, a halfword or a word. Each side of the copy either walks forward through memory or stays on one address, as a peripheral data register would.

A transfer starts in one of two ways. A software trigger starts a memory-to-memory copy. A request line picked from eight hardware request inputs starts a peripheral-paced copy. The service mode sets how much work one trigger buys: either a single unit or the whole remaining count. Hardware requests are taken either as a level (demand) or as a rising edge (handshake).

At terminal count the channel can raise a one-cycle interrupt. It then either switches itself off, or restores its start addresses and count and stays armed. A stop command ends an active transfer at once.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is off and not busy. Every register reads zero, and `mem_req` and `irq` are low.
- R2: Configuration registers read back what was written. Source address is at 0x00 and its side control at 0x04 (bits [1:0]). Destination address is at 0x08 and its side control at 0x0C (bits [2:0]). The control word is at 0x10 (all 32 bits). The request-select register is at 0x24 (bits [3:0]).
- R3: Writing 1 to bit 1 (on) of the trigger register at 0x20 while the channel is off arms it. Arming copies the start addresses and loads the live count from control bits [19:0]. Status at 0x14 shows the live count in bits [19:0] and busy in bit 20. The trigger register reads back the on state in bit 1.
- R4: With control bit 23 clear (software trigger), writing bit 0 together with bit 1 of the trigger register starts the channel. Each unit is a read of the source followed by a write of the read data to the destination. With control bit 27 set (whole service), every unit of the count runs from that one trigger.
- R5: Control bits [21:20] give the unit size: 0 is byte, 1 is halfword, 2 is word. The size is driven on `mem_size`. A side whose control bit 0 is clear steps by 1, 2 or 4 after each unit. A side whose bit 0 is set keeps its address.
- R6: With control bit 27 clear (single service), one trigger moves one unit. Busy then drops while the channel stays on, with the live count one lower.
- R7: With control bit 23 set, requests come from line `hw_req[sel]`. `sel` is control bits [26:24], unless request-select bit 0 is set, in which case `sel` is request-select bits [3:1]. With control bit 31 clear (demand) a high level triggers. With bit 31 set (handshake) only a rising edge triggers. Other lines have no effect.
- R8: When the live count reaches zero with control bit 22 set, the channel clears on and busy. If control bit 29 is set, `irq` pulses high for exactly one cycle.
- R9: When the live count reaches zero with control bit 22 clear, the channel restores the start addresses and count and stays on. The next trigger repeats the same addresses.
- R10: Writing the trigger register with bit 2 set, or with bit 1 clear, switches the channel off and ends an active transfer. `mem_req` drops in the next cycle. Bit 2 overrides bit 1.
- R11: While busy, writes to the address, side-control, control and request-select registers are ignored.
- R12: A trigger is ignored while the channel is off or while the live count is zero.
- R13: Once raised, `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Register write when high |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| hw_req | input | 8 | Hardware request lines |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Access completes on this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The bench builds the engine with its default 32-bit address and data paths and the fixed eight request lines. With eight lines the bench can hold a wrong line high to show it is ignored, and can route a line through the select override. Since the count field is fixed at 20 bits by the register layout, the bench keeps counts to a few units, so terminal count, reload and the zero-count case all come up in short runs. A memory responder with varying wait states and a stall switch lets the bench hold an access open, which exposes the stop path and the busy write lock.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int CNT_W     = 20;
    localparam int REQ_LINES = 8;

    // control word bit positions
    localparam int C_SIZE_LO = 20;
    localparam int C_NORLD   = 22;
    localparam int C_HWTRIG  = 23;
    localparam int C_SEL_LO  = 24;
    localparam int C_WHOLE   = 27;
    localparam int C_INTEN   = 29;
    localparam int C_HSHAKE  = 31;
    localparam int S_BUSY    = 20;

    // register offsets
    localparam logic [5:0] O_SRC  = 6'h00;
    localparam logic [5:0] O_SCTL = 6'h04;
    localparam logic [5:0] O_DST  = 6'h08;
    localparam logic [5:0] O_DCTL = 6'h0C;
    localparam logic [5:0] O_CTRL = 6'h10;
    localparam logic [5:0] O_STAT = 6'h14;
    localparam logic [5:0] O_TRIG = 6'h20;
    localparam logic [5:0] O_RSEL = 6'h24;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_READ  = 2'd1,
        XS_WRITE = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    input  logic          fixed_i,
    output logic [AW-1:0] next_o
);
    logic [AW-1:0] step;

    always_comb begin
        if (fixed_i) begin
            step = '0;
        end else begin
            case (size_i)
                2'd0:    step = AW'(1);
                2'd1:    step = AW'(2);
                default: step = AW'(4);
            endcase
        end
        next_o = addr_i + step;
    end
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
    import dma_chan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REQ_LINES-1:0] req_i,
    input  logic [2:0]           sel_i,
    input  logic                 edge_i,
    output logic                 fire_o
);
    logic [REQ_LINES-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = req_i;
        if (edge_i) fire_o = req_i[sel_i] & ~prev_q[sel_i];
        else        fire_o = req_i[sel_i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_en,
    input  logic                 reg_we,
    input  logic [5:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [REQ_LINES-1:0] hw_req,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [1:0]           mem_size,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 mem_ack,
    input  logic [DW-1:0]        mem_rdata,
    output logic                 irq
);
    localparam int NSIDE = 2;

    typedef struct packed {
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [AW-1:0]    cur_src;
        logic [AW-1:0]    cur_dst;
        logic [1:0]       src_ctl;
        logic [2:0]       dst_ctl;
        logic [31:0]      ctrl;
        logic [CNT_W-1:0] cnt;
        logic [3:0]       rsel;
        logic             on;
        logic             busy;
        xfer_st_e         st;
        logic [DW-1:0]    dbuf;
        logic             irq;
    } regs_t;

    regs_t q, n;

    logic             cfg_wr, trig_wr, arm, sw_trig, on_after, hw_fire, trig;
    logic [CNT_W-1:0] eff_cnt, cnt_m1;
    logic [2:0]       req_sel;
    logic [AW-1:0]    side_addr  [NSIDE];
    logic             side_fixed [NSIDE];
    logic [AW-1:0]    side_next  [NSIDE];

    assign side_addr[0]  = q.cur_src;
    assign side_addr[1]  = q.cur_dst;
    assign side_fixed[0] = q.src_ctl[0];
    assign side_fixed[1] = q.dst_ctl[0];

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_addr_step #(.AW(AW)) u_step (
            .addr_i  (side_addr[g]),
            .size_i  (q.ctrl[C_SIZE_LO+1:C_SIZE_LO]),
            .fixed_i (side_fixed[g]),
            .next_o  (side_next[g])
        );
    end

    assign req_sel = q.rsel[0] ? q.rsel[3:1] : q.ctrl[C_SEL_LO+2:C_SEL_LO];

    dma_req_detect u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (hw_req),
        .sel_i  (req_sel),
        .edge_i (q.ctrl[C_HSHAKE]),
        .fire_o (hw_fire)
    );

    always_comb begin
        n       = q;
        n.irq   = 1'b0;
        cfg_wr  = reg_en && reg_we && !q.busy;
        trig_wr = reg_en && reg_we && (reg_addr == O_TRIG);
        arm     = trig_wr && reg_wdata[1] && !reg_wdata[2] && !q.on;
        sw_trig = trig_wr && reg_wdata[0];
        on_after = trig_wr ? (reg_wdata[1] && !reg_wdata[2]) : q.on;
        eff_cnt = arm ? q.ctrl[CNT_W-1:0] : q.cnt;
        cnt_m1  = q.cnt - 1'b1;
        trig    = q.ctrl[C_HWTRIG] ? hw_fire : sw_trig;

        if (cfg_wr) begin
            case (reg_addr)
                O_SRC:  n.src     = reg_wdata[AW-1:0];
                O_SCTL: n.src_ctl = reg_wdata[1:0];
                O_DST:  n.dst     = reg_wdata[AW-1:0];
                O_DCTL: n.dst_ctl = reg_wdata[2:0];
                O_CTRL: n.ctrl    = reg_wdata;
                O_RSEL: n.rsel    = reg_wdata[3:0];
                default: ;
            endcase
        end

        case (q.st)
            XS_READ: begin
                if (mem_ack) begin
                    n.dbuf = mem_rdata;
                    n.st   = XS_WRITE;
                end
            end
            XS_WRITE: begin
                if (mem_ack) begin
                    n.cnt     = cnt_m1;
                    n.cur_src = side_next[0];
                    n.cur_dst = side_next[1];
                    if (cnt_m1 == '0) begin
                        n.irq  = q.ctrl[C_INTEN];
                        n.busy = 1'b0;
                        n.st   = XS_IDLE;
                        if (q.ctrl[C_NORLD]) begin
                            n.on = 1'b0;
                        end else begin
                            n.cur_src = q.src;
                            n.cur_dst = q.dst;
                            n.cnt     = q.ctrl[CNT_W-1:0];
                        end
                    end else if (q.ctrl[C_WHOLE]) begin
                        n.st = XS_READ;
                    end else begin
                        n.busy = 1'b0;
                        n.st   = XS_IDLE;
                    end
                end
            end
            default: ;
        endcase

        if (trig_wr) begin
            n.on = on_after;
            if (!on_after) begin
                n.busy = 1'b0;
                n.st   = XS_IDLE;
            end
            if (arm) begin
                n.cur_src = q.src;
                n.cur_dst = q.dst;
                n.cnt     = q.ctrl[CNT_W-1:0];
            end
        end

        if (on_after && !q.busy && trig && (eff_cnt != '0)) begin
            n.busy = 1'b1;
            n.st   = XS_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_comb begin
        case (reg_addr)
            O_SRC:   reg_rdata = 32'(q.src);
            O_SCTL:  reg_rdata = {30'd0, q.src_ctl};
            O_DST:   reg_rdata = 32'(q.dst);
            O_DCTL:  reg_rdata = {29'd0, q.dst_ctl};
            O_CTRL:  reg_rdata = q.ctrl;
            O_STAT:  reg_rdata = {11'd0, q.busy, q.cnt};
            O_TRIG:  reg_rdata = {30'd0, q.on, 1'b0};
            O_RSEL:  reg_rdata = {28'd0, q.rsel};
            default: reg_rdata = '0;
        endcase
    end

    assign mem_req   = (q.st != XS_IDLE);
    assign mem_we    = (q.st == XS_WRITE);
    assign mem_addr  = (q.st == XS_WRITE) ? q.cur_dst : q.cur_src;
    assign mem_size  = q.ctrl[C_SIZE_LO+1:C_SIZE_LO];
    assign mem_wdata = q.dbuf;
    assign irq       = q.irq;

    // R6: a busy channel is always switched on
    a_r6_busy_on: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> q.on);

    // R4: memory traffic only inside a busy transfer
    a_r4_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> q.busy);

    // R13: an open access holds until acknowledged unless stopped
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !trig_wr) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: stop ends everything on the next cycle
    a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_wr && reg_wdata[2]) |=> (!q.on && !q.busy && !mem_req));

    // R8: interrupt after a no-reload terminal count finds the channel off
    a_r8_tc_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && q.ctrl[C_NORLD] && !$past(trig_wr)) |-> !q.on);

    // R8: the interrupt is a single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R11: configuration is frozen while busy
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |=> ($stable(q.src) && $stable(q.dst) && $stable(q.ctrl)));
endmodule

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [31:0] K_NORLD  = 32'h1 << 22;
    localparam logic [31:0] K_HW     = 32'h1 << 23;
    localparam logic [31:0] K_WHOLE  = 32'h1 << 27;
    localparam logic [31:0] K_INT    = 32'h1 << 29;
    localparam logic [31:0] K_HSHAKE = 32'h1 << 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [7:0]  hw_req = '0;
    logic        mem_req, mem_we, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    dma_chan_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hw_req(hw_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        we;
        logic [31:0] addr;
        logic [1:0]  size;
        logic [31:0] data;
    } item_t;

    item_t exp_q[$];
    int  total = 0, bad = 0, irq_cnt = 0, pace = 0, wait_left = 0;
    bit  mem_stall = 1'b0, done = 1'b0;

    function automatic void chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic logic [31:0] mem_val(logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
    endfunction

    task automatic push_units(input logic [31:0] s, input logic [31:0] d, input logic [1:0] sz,
                              input int units, input bit sfix, input bit dfix);
        logic [31:0] st;
        st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        for (int i = 0; i < units; i++) begin
            exp_q.push_back('{1'b0, s, sz, 32'd0});
            exp_q.push_back('{1'b1, d, sz, mem_val(s)});
            if (!sfix) s = s + st;
            if (!dfix) d = d + st;
        end
    endtask

    // monitor and memory responder: scoreboard compare at the accepting edge
    always @(negedge clk) begin
        item_t it;
        if (irq) irq_cnt++;
        if (!rst_n) mem_ack = 1'b0;
        else if (mem_ack) mem_ack = 1'b0;
        else if (mem_req && !mem_stall) begin
            if (wait_left != 0) wait_left--;
            else begin
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected access", mem_addr, 32'd0);
                else begin
                    it = exp_q.pop_front();
                    chk(mem_we == it.we && mem_addr == it.addr && mem_size == it.size,
                        "R4/R5 access", {mem_we, mem_size, mem_addr[28:0]},
                        {it.we, it.size, it.addr[28:0]});
                    if (it.we) chk(mem_wdata == it.data, "R4 write data", mem_wdata, it.data);
                end
                mem_rdata = mem_val(mem_addr);
                mem_ack = 1'b1;
                pace++;
                wait_left = pace % 2;
            end
        end
    end

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_off(input string tag);
        logic [31:0] v;
        bit ok = 1'b0;
        for (int i = 0; i < 400 && !ok; i++) begin
            reg_rd(6'h20, v);
            if (!v[1]) ok = 1'b1;
        end
        chk(ok, tag, 32'd0, 32'd1);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        bit ok = 1'b0;
        for (int i = 0; i < 400 && !ok; i++) begin
            reg_rd(6'h14, v);
            if (!v[20]) ok = 1'b1;
        end
        chk(ok, tag, 32'd0, 32'd1);
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] sc, input logic [31:0] d,
                         input logic [31:0] dc, input logic [31:0] c);
        reg_wr(6'h00, s); reg_wr(6'h04, sc); reg_wr(6'h08, d);
        reg_wr(6'h0C, dc); reg_wr(6'h10, c);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a0;
        int ic;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(6'h14, v); chk(v == 0, "R1 status", v, 0);
        reg_rd(6'h20, v); chk(v == 0, "R1 trigger reg", v, 0);
        reg_rd(6'h10, v); chk(v == 0, "R1 control", v, 0);
        chk(mem_req == 0 && irq == 0, "R1 outputs", {mem_req, irq}, 0);

        // R2 readback
        reg_wr(6'h00, 32'h1234_5678); reg_rd(6'h00, v); chk(v == 32'h1234_5678, "R2 src", v, 32'h1234_5678);
        reg_wr(6'h04, 32'hFFFF_FFFF); reg_rd(6'h04, v); chk(v == 32'h3, "R2 src ctl", v, 3);
        reg_wr(6'h0C, 32'hFFFF_FFFF); reg_rd(6'h0C, v); chk(v == 32'h7, "R2 dst ctl", v, 7);
        reg_wr(6'h10, 32'hA5C3_0F0F); reg_rd(6'h10, v); chk(v == 32'hA5C3_0F0F, "R2 ctrl", v, 32'hA5C3_0F0F);
        reg_wr(6'h24, 32'hFFFF_FFFF); reg_rd(6'h24, v); chk(v == 32'hF, "R2 reqsel", v, 32'hF);
        reg_wr(6'h24, 32'h0);

        // R3/R4/R8 software whole, word, both incrementing, interrupt
        setup(32'h100, 0, 32'h200, 0, K_WHOLE | K_INT | K_NORLD | (32'd2 << 20) | 32'd3);
        push_units(32'h100, 32'h200, 2'd2, 3, 0, 0);
        reg_wr(6'h20, 32'h2);
        reg_rd(6'h14, v); chk(v == 32'd3, "R3 armed count", v, 3);
        reg_rd(6'h20, v); chk(v == 32'h2, "R3 on readback", v, 2);
        ic = irq_cnt;
        reg_wr(6'h20, 32'h3);
        wait_off("R8 channel off at terminal");
        repeat (2) @(negedge clk);
        chk(irq_cnt == ic + 1, "R8 single irq pulse", irq_cnt - ic, 1);
        reg_rd(6'h14, v); chk(v == 0, "R8 status idle zero", v, 0);
        chk(exp_q.size() == 0, "R4 all units seen", exp_q.size(), 0);

        // R5 halfword, fixed destination
        setup(32'h302, 0, 32'h400, 1, K_WHOLE | K_NORLD | (32'd1 << 20) | 32'd2);
        push_units(32'h302, 32'h400, 2'd1, 2, 0, 1);
        reg_wr(6'h20, 32'h3);
        wait_off("R5 halfword done");
        // R5 byte, fixed source
        setup(32'h301, 1, 32'h401, 0, K_WHOLE | K_NORLD | 32'd2);
        push_units(32'h301, 32'h401, 2'd0, 2, 1, 0);
        reg_wr(6'h20, 32'h3);
        wait_off("R5 byte done");
        chk(exp_q.size() == 0, "R5 all units seen", exp_q.size(), 0);

        // R6 single service by software
        setup(32'h500, 0, 32'h600, 0, K_NORLD | (32'd2 << 20) | 32'd2);
        push_units(32'h500, 32'h600, 2'd2, 2, 0, 0);
        ic = irq_cnt;
        reg_wr(6'h20, 32'h3);
        wait_idle("R6 unit done");
        reg_rd(6'h14, v); chk(v == 32'd1, "R6 count after one unit", v, 1);
        reg_rd(6'h20, v); chk(v == 32'h2, "R6 still on", v, 2);
        reg_wr(6'h20, 32'h3);
        wait_off("R6 second unit ends");
        chk(irq_cnt == ic, "R8 no irq when disabled", irq_cnt - ic, 0);

        // R11/R13 writes ignored while busy, access held while stalled
        setup(32'h800, 0, 32'h900, 0, K_WHOLE | K_NORLD | (32'd2 << 20) | 32'd2);
        push_units(32'h800, 32'h900, 2'd2, 2, 0, 0);
        mem_stall = 1'b1;
        reg_wr(6'h20, 32'h3);
        reg_wr(6'h00, 32'hDEAD_0000);
        reg_wr(6'h10, 32'd5);
        reg_rd(6'h00, v); chk(v == 32'h800, "R11 src frozen", v, 32'h800);
        reg_rd(6'h10, v); chk(v[19:0] == 20'd2, "R11 ctrl frozen", v, 2);
        a0 = mem_addr;
        repeat (3) @(negedge clk);
        chk(mem_req && mem_addr == a0 && a0 == 32'h800, "R13 held access", mem_addr, 32'h800);
        mem_stall = 1'b0;
        wait_off("R11 transfer completes");
        chk(exp_q.size() == 0, "R11 units seen", exp_q.size(), 0);

        // R10 stop overrides on
        setup(32'hA00, 0, 32'hB00, 0, K_WHOLE | K_NORLD | (32'd2 << 20) | 32'd4);
        mem_stall = 1'b1;
        reg_wr(6'h20, 32'h3);
        reg_wr(6'h20, 32'h6);
        chk(mem_req == 0, "R10 request dropped", mem_req, 0);
        reg_rd(6'h14, v); chk(v[20] == 0, "R10 not busy", v, 0);
        reg_rd(6'h20, v); chk(v == 0, "R10 off", v, 0);
        mem_stall = 1'b0;
        repeat (5) @(negedge clk);

        // R12 trigger while off, and zero count
        reg_wr(6'h20, 32'h1);
        repeat (5) @(negedge clk);
        reg_rd(6'h14, v); chk(v[20] == 0, "R12 trigger while off", v, 0);
        reg_wr(6'h10, K_WHOLE | K_NORLD);
        reg_wr(6'h20, 32'h3);
        repeat (5) @(negedge clk);
        reg_rd(6'h14, v); chk(v == 0, "R12 zero count ignored", v, 0);
        chk(mem_req == 0, "R12 no request", mem_req, 0);
        reg_wr(6'h20, 32'h0);

        // R7 demand on line 5
        setup(32'hC00, 0, 32'hD00, 0, K_HW | K_NORLD | (32'd5 << 24) | (32'd2 << 20) | 32'd2);
        push_units(32'hC00, 32'hD00, 2'd2, 2, 0, 0);
        reg_wr(6'h20, 32'h2);
        hw_req = 8'h08;
        repeat (10) @(negedge clk);
        reg_rd(6'h14, v); chk(v == 32'd2, "R7 wrong line ignored", v, 2);
        hw_req = 8'h20;
        wait_off("R7 demand runs both units");
        hw_req = 8'h00;

        // R7 handshake on line 2 via select override
        reg_wr(6'h24, 32'h5);
        setup(32'hE00, 0, 32'hF00, 0, K_HW | K_HSHAKE | K_NORLD | 32'd2);
        push_units(32'hE00, 32'hF00, 2'd0, 2, 0, 0);
        reg_wr(6'h20, 32'h2);
        hw_req = 8'h04;
        repeat (20) @(negedge clk);
        reg_rd(6'h14, v); chk(v == 32'd1, "R7 one unit per edge", v, 1);
        hw_req = 8'h00;
        repeat (2) @(negedge clk);
        hw_req = 8'h04;
        wait_off("R7 second edge finishes");
        hw_req = 8'h00;
        reg_wr(6'h24, 32'h0);
        chk(exp_q.size() == 0, "R7 units seen", exp_q.size(), 0);

        // R9 auto-reload
        setup(32'h1A00, 0, 32'h1B00, 0, K_WHOLE | K_INT | (32'd2 << 20) | 32'd2);
        push_units(32'h1A00, 32'h1B00, 2'd2, 2, 0, 0);
        ic = irq_cnt;
        reg_wr(6'h20, 32'h3);
        for (int i = 0; i < 200 && irq_cnt == ic; i++) @(negedge clk);
        chk(irq_cnt == ic + 1, "R9 irq at reload", irq_cnt - ic, 1);
        reg_rd(6'h20, v); chk(v == 32'h2, "R9 stays on", v, 2);
        reg_rd(6'h14, v); chk(v == 32'd2, "R9 count restored", v, 2);
        push_units(32'h1A00, 32'h1B00, 2'd2, 2, 0, 0);
        reg_wr(6'h20, 32'h3);
        for (int i = 0; i < 200 && irq_cnt == ic + 1; i++) @(negedge clk);
        reg_wr(6'h20, 32'h4);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 repeat same addresses", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule